// File: doc/BRIEF.md
# Sampling Converter Control and Output Port

This block is the digital front of a 12-bit sampling converter. A host reaches it through three control inputs: an active-low chip select, a read/convert line and a high-byte select. The block tells a falling edge on read/convert apart from every other input change, starts a fixed-length conversion timed by an internal counter, and shows the conversion in progress on a status output that is low while the conversion runs. At the end of the conversion it captures the value on a stand-in result input and holds it in a register, which the host then reads over a parallel bus. Analog sampling and the conversion arithmetic are not part of the block; the bench supplies the result value.

Both start styles work. In convert mode the host pulses read/convert low and returns it high while the conversion runs; the new result appears once the status output rises. In read mode read/convert idles low; raising it shows the previous result, and its falling edge starts the next conversion. The bus is either a full 12-bit word or an 8-bit bus on which the high-byte select picks the byte. High impedance is shown as `dataEn` low with `dataOut` at zero.

Top module: `adc_host_port`

## Requirements
- R1: A conversion starts at a clock edge where `rdConv` is 0, `rdConv` was 1 at the edge before, `selN` is 0, `hiByteSel` is 0 and no conversion is running; `notBusy` is 0 from that edge on.
- R2: No start occurs when `selN` or `hiByteSel` is 1 at the falling edge, on a rising edge of `rdConv`, or when `selN` falls while `rdConv` stays low.
- R3: `notBusy` stays 0 for exactly CONV_CYCLES clocks (default 130 clocks at 50 MHz, 2.6 us; the count is clamped so that it never exceeds MAX_CONV_NS, 2.7 us) and is 1 at all other times.
- R4: While `notBusy` is 0, changes on `selN`, `rdConv` and `hiByteSel` neither abort nor restart the conversion, and a falling edge of `rdConv` seen during the conversion does not start one after it ends.
- R5: While `notBusy` is 0, `dataEn` is 0.
- R6: `dataEn` is 1 exactly when `rdConv` is 1, `notBusy` is 1 and `selN` is 0, at the same moment (no clock delay); whenever `dataEn` is 0, `dataOut` is all zeros.
- R7: With `byteMode` 0 and `dataEn` 1, `dataOut` carries the 12-bit result.
- R8: With `byteMode` 1 and `dataEn` 1, `dataOut[11:8]` is 0; `hiByteSel` 0 puts result bits 7:0 on `dataOut[7:0]`; `hiByteSel` 1 puts result bits 11:8 on `dataOut[3:0]` with `dataOut[7:4]` zero.
- R9: The result register loads `resultIn` only at the edge where `notBusy` returns to 1, so the previous result stays readable until then.
- R10: While `rstN` is 0, `notBusy` is 1 and `dataEn` is 0; after reset the result register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| selN | input | 1 | Active-low chip select |
| rdConv | input | 1 | Read/convert line; its falling edge starts a conversion |
| hiByteSel | input | 1 | High-byte select; blocks a start when high |
| byteMode | input | 1 | 1 selects the 8-bit bus, 0 the 12-bit word |
| resultIn | input | 12 | Stand-in conversion result, captured at the end of a conversion |
| notBusy | output | 1 | Low only while a conversion runs |
| dataOut | output | 12 | Parallel data bus, zero when not driven |
| dataEn | output | 1 | Bus drive enable; 0 stands for high impedance |

## Verification
The bench tries every chip-select and high-byte combination at a falling edge, plus rising edges and chip-select edges under a steady low read/convert. A design that took a level as a start, or that left out a qualifier, would start conversions here that it must not. It toggles all three controls during conversions and leaves read/convert low across the end of one. A design that aborted, restarted or kept a stale edge would show a wrong busy length or a spurious second conversion. It changes the result input in the middle of each conversion and again right after the end, and sweeps all sixteen control/mode combinations while idle. A design that captured at start, kept capturing after the end, gated the bus one cycle late or steered the wrong nibble would read back a value different from the one computed in the bench.

// File: rtl/adc_port_pkg.sv
package adc_port_pkg;

  // Strobes passed from the control to the datapath
  typedef struct packed {
    logic startPulse;   // start accepted at this edge
    logic captureNow;   // last busy cycle: load the result at this edge
    logic busyNow;      // conversion in progress
  } ctrlStrobesT;

  // Cycle count for a duration in ns at a clock in MHz
  function automatic int nsToCycles(input int ns, input int mhz);
    return (ns * mhz) / 1000;
  endfunction

endpackage

// File: rtl/adc_port_ctrl.sv
module adc_port_ctrl
  import adc_port_pkg::*;
#(
  parameter int CLK_MHZ     = 50,
  parameter int CONV_NS     = 2600,
  parameter int MAX_CONV_NS = 2700
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        selN,
  input  logic        rdConv,
  input  logic        hiByteSel,
  output ctrlStrobesT strobes,
  output logic        notBusy
);

  localparam int REQ_CYCLES  = nsToCycles(CONV_NS, CLK_MHZ);
  localparam int MAX_CYCLES  = nsToCycles(MAX_CONV_NS, CLK_MHZ);
  localparam int LIM_CYCLES  = (REQ_CYCLES > MAX_CYCLES) ? MAX_CYCLES : REQ_CYCLES;
  localparam int CONV_CYCLES = (LIM_CYCLES < 1) ? 1 : LIM_CYCLES;
  localparam int CNT_W       = $clog2(CONV_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(CONV_CYCLES - 1);

  logic             rdPrev;
  logic             converting;
  logic [CNT_W-1:0] cnt;
  logic             fallSeen;
  logic             startHit;
  logic             lastCycle;

  // Falling edge of read/convert between two consecutive clock edges
  assign fallSeen  = rdPrev && !rdConv;
  // Qualified start: idle, selected, high byte not requested
  assign startHit  = fallSeen && !converting && !selN && !hiByteSel;
  assign lastCycle = converting && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdPrev     <= 1'b0;
      converting <= 1'b0;
      cnt        <= '0;
    end else begin
      rdPrev <= rdConv;
      if (startHit) begin
        converting <= 1'b1;
        cnt        <= CNT_LOAD;
      end else if (converting) begin
        if (cnt == '0) begin
          converting <= 1'b0;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end

  always_comb begin
    strobes            = '0;
    strobes.startPulse = startHit;
    strobes.captureNow = lastCycle;
    strobes.busyNow    = converting;
  end

  assign notBusy = !converting;

  // R1
  start_on_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.startPulse |-> ($past(rdConv) && !rdConv));

  // R2
  blocked_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (notBusy && (selN || hiByteSel)) |=> notBusy);

  // R3
  busy_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(notBusy) |-> (cnt == CNT_LOAD));

  // R4
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!notBusy && cnt != '0) |=> (!notBusy && cnt == $past(cnt) - 1'b1));

  // R3
  busy_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(notBusy) |-> ($past(cnt) == '0));

endmodule

// File: rtl/adc_port_datapath.sv
module adc_port_datapath
  import adc_port_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobesT       strobes,
  input  logic [DATA_W-1:0] resultIn,
  input  logic              selN,
  input  logic              rdConv,
  input  logic              hiByteSel,
  input  logic              byteMode,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataEn
);

  localparam int HI_W = DATA_W - BYTE_W;

  logic [DATA_W-1:0] resultQ;
  logic [BYTE_W-1:0] byteLane;
  logic [DATA_W-1:0] steered;

  // Result register: loaded only on the last busy cycle
  always_ff @(posedge clk) begin
    if (!rstN) begin
      resultQ <= '0;
    end else if (strobes.captureNow) begin
      resultQ <= resultIn;
    end
  end

  // Byte steering for the narrow bus
  generate
    if (HI_W > 0) begin : gSplit
      always_comb begin
        if (hiByteSel) begin
          byteLane = BYTE_W'(resultQ[DATA_W-1:BYTE_W]);
        end else begin
          byteLane = resultQ[BYTE_W-1:0];
        end
      end
    end else begin : gNarrow
      assign byteLane = BYTE_W'(resultQ);
    end
  endgenerate

  always_comb begin
    steered = '0;
    if (byteMode) begin
      steered[BYTE_W-1:0] = byteLane;
    end else begin
      steered = resultQ;
    end
  end

  // Bus gate: read high, not busy, selected; held off in reset
  assign dataEn  = rstN && rdConv && !strobes.busyNow && !selN;
  assign dataOut = dataEn ? steered : '0;

  // R5
  hiz_while_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.busyNow |-> !dataEn);

  // R6
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !dataEn |-> (dataOut == '0));

  // R8
  byte_upper_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dataEn && byteMode) |-> (dataOut[DATA_W-1:BYTE_W] == '0));

  // R9
  result_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.captureNow |=> $stable(resultQ));

  // R9
  capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.captureNow |=> (resultQ == $past(resultIn)));

endmodule

// File: rtl/adc_host_port.sv
module adc_host_port
  import adc_port_pkg::*;
#(
  parameter int CLK_MHZ     = 50,
  parameter int CONV_NS     = 2600,
  parameter int MAX_CONV_NS = 2700,
  parameter int DATA_W      = 12,
  parameter int BYTE_W      = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              selN,
  input  logic              rdConv,
  input  logic              hiByteSel,
  input  logic              byteMode,
  input  logic [DATA_W-1:0] resultIn,
  output logic              notBusy,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataEn
);

  ctrlStrobesT strobes;

  adc_port_ctrl #(
    .CLK_MHZ    (CLK_MHZ),
    .CONV_NS    (CONV_NS),
    .MAX_CONV_NS(MAX_CONV_NS)
  ) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .selN     (selN),
    .rdConv   (rdConv),
    .hiByteSel(hiByteSel),
    .strobes  (strobes),
    .notBusy  (notBusy)
  );

  adc_port_datapath #(
    .DATA_W(DATA_W),
    .BYTE_W(BYTE_W)
  ) uData (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .resultIn (resultIn),
    .selN     (selN),
    .rdConv   (rdConv),
    .hiByteSel(hiByteSel),
    .byteMode (byteMode),
    .dataOut  (dataOut),
    .dataEn   (dataEn)
  );

  // R10
  reset_idle_chk: assert property (@(posedge clk)
    !rstN |-> !dataEn);

endmodule

// File: tb/tb_adc_host_port.sv
module tb_adc_host_port;

  localparam int CONV = 130;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        selN = 1'b1;
  logic        rdConv = 1'b1;
  logic        hiByteSel = 1'b0;
  logic        byteMode = 1'b0;
  logic [11:0] resultIn = '0;
  logic        notBusy;
  logic [11:0] dataOut;
  logic        dataEn;

  int checks = 0;
  int failures = 0;
  logic [11:0] lastRes = '0;

  always #10 clk = ~clk;

  adc_host_port dut (
    .clk(clk), .rstN(rstN), .selN(selN), .rdConv(rdConv),
    .hiByteSel(hiByteSel), .byteMode(byteMode), .resultIn(resultIn),
    .notBusy(notBusy), .dataOut(dataOut), .dataEn(dataEn)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  function automatic logic [11:0] expOut(input logic [11:0] res, input logic bm, input logic hb);
    if (!bm) return res;
    if (hb) return res >> 8;
    return res & 12'h0ff;
  endfunction

  // Waits for notBusy to rise; returns the number of busy cycles seen so far plus the rest
  task automatic waitEnd(inout int cnt, inout int enErr);
    while (!notBusy && cnt < 1000) begin
      if (dataEn) enErr++;
      step();
      if (!notBusy) cnt++;
    end
  endtask

  // Convert mode: negative pulse, result changed mid-conversion
  task automatic convertOnce(input logic [11:0] firstVal, input logic [11:0] midVal);
    int cnt;
    int enErr;
    rdConv = 1'b1; selN = 1'b0; hiByteSel = 1'b0; byteMode = 1'b0;
    step();
    resultIn = firstVal;
    rdConv = 1'b0;
    step();
    check("R1 start on falling edge", notBusy, 0);
    rdConv = 1'b1;
    cnt = 1; enErr = 0;
    while (!notBusy && cnt < 1000) begin
      if (dataEn) enErr++;
      if (cnt == CONV / 2) resultIn = midVal;
      step();
      if (!notBusy) cnt++;
    end
    check("R3 busy length", cnt, CONV);
    check("R5 bus off while busy", enErr, 0);
    resultIn = ~midVal;
    #1;
    check("R7 full word after end", dataOut, midVal);
    check("R6 enable after end", dataEn, 1);
    step();
    check("R9 no capture after end", dataOut, midVal);
    byteMode = 1'b1; hiByteSel = 1'b0; #1;
    check("R8 low byte", dataOut, expOut(midVal, 1'b1, 1'b0));
    hiByteSel = 1'b1; #1;
    check("R8 high byte", dataOut, expOut(midVal, 1'b1, 1'b1));
    hiByteSel = 1'b0; byteMode = 1'b0;
    step();
    lastRes = midVal;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int cnt;
    int enErr;
    // Reset state
    selN = 1'b0; rdConv = 1'b1;
    repeat (3) step();
    check("R10 notBusy in reset", notBusy, 1);
    check("R10 bus off in reset", dataEn, 0);
    rstN = 1'b1;
    step();
    check("R10 enable after reset", dataEn, 1);
    check("R10 result zero after reset", dataOut, 0);

    // Start qualifier sweep at a falling edge
    for (int q = 0; q < 4; q++) begin
      rdConv = 1'b1; selN = q[0]; hiByteSel = q[1];
      step(); step();
      rdConv = 1'b0;
      step();
      check((q == 0) ? "R1 qualified start" : "R2 blocked start", notBusy, (q == 0) ? 0 : 1);
      cnt = 1; enErr = 0;
      if (!notBusy) begin
        waitEnd(cnt, enErr);
        check("R3 sweep busy length", cnt, CONV);
      end
      rdConv = 1'b1; selN = 1'b0; hiByteSel = 1'b0;
      step();
    end

    // Rising edge and chip-select edge under low read/convert
    selN = 1'b1; rdConv = 1'b0; step();
    selN = 1'b0; step(); step();
    check("R2 select fall with read low", notBusy, 1);
    rdConv = 1'b1; step(); step();
    check("R2 rising edge", notBusy, 1);

    // Convert mode over several results
    for (int i = 0; i < 8; i++) begin
      convertOnce(12'((i * 1237) & 12'hfff), 12'((i * 499 + 12'h5a3) & 12'hfff));
    end
    convertOnce(12'h000, 12'hfff);

    // Inputs toggled during a conversion
    rdConv = 1'b1; selN = 1'b0; hiByteSel = 1'b0; step();
    resultIn = 12'h3c6;
    rdConv = 1'b0; step();
    cnt = 1; enErr = 0;
    while (!notBusy && cnt < 1000) begin
      if (dataEn) enErr++;
      if (cnt < CONV - 4) begin
        rdConv = cnt[0]; selN = cnt[1]; hiByteSel = cnt[2];
      end else begin
        rdConv = 1'b1; selN = 1'b0; hiByteSel = 1'b0;
      end
      step();
      if (!notBusy) cnt++;
    end
    check("R4 no abort or restart", cnt, CONV);
    check("R5 bus off while toggling", enErr, 0);
    step(); step();
    check("R4 idle after toggled conversion", notBusy, 1);
    check("R7 result after toggled conversion", dataOut, 12'h3c6);

    // Falling edge held across the end of a conversion
    rdConv = 1'b1; step();
    resultIn = 12'h81e;
    rdConv = 1'b0; step();
    rdConv = 1'b1; step();
    rdConv = 1'b0;
    cnt = 2; enErr = 0;
    waitEnd(cnt, enErr);
    check("R3 busy length with late fall", cnt, CONV);
    step(); step(); step();
    check("R4 stale fall ignored", notBusy, 1);
    check("R6 bus off with read low", dataEn, 0);
    lastRes = 12'h81e;

    // Read mode: positive pulse shows previous result, its fall starts
    resultIn = 12'h2d7;
    rdConv = 1'b1; #1;
    check("R9 previous result in read mode", dataOut, 12'h81e);
    step();
    rdConv = 1'b0; step();
    check("R1 read-mode start", notBusy, 0);
    cnt = 1; enErr = 0;
    waitEnd(cnt, enErr);
    check("R3 read-mode busy length", cnt, CONV);
    check("R6 bus off after read-mode end", dataEn, 0);
    rdConv = 1'b1; #1;
    check("R7 read-mode new result", dataOut, 12'h2d7);
    lastRes = 12'h2d7;

    // Idle gating sweep over read, select, byte select and bus mode
    for (int k = 0; k < 16; k++) begin
      selN = 1'b1; step();
      rdConv = k[0]; step();
      selN = k[1]; hiByteSel = k[2]; byteMode = k[3]; step();
      check("R6 idle gate", dataEn, (k[0] && !k[1]) ? 1 : 0);
      check("R8 idle steering", dataOut,
            (k[0] && !k[1]) ? expOut(lastRes, k[3], k[2]) : 12'h000);
    end
    check("R2 no start during sweep", notBusy, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule